// File: doc/BRIEF.md
# Logical ALU with flag generation

This block is the bitwise half of the execute stage of an 8-bit accumulator processor. It is purely combinational. It takes the current accumulator, one operand byte that an upstream decoder has already fetched, a three-bit operation select and the current flag byte. In the same cycle it produces the next accumulator value, a write strobe for the accumulator register and the next flag byte.

Five operations are supported: AND, OR, XOR, test-AND (TST) and one's complement of the accumulator (CPL). TST evaluates the AND result only to set the flags and leaves the accumulator alone. CPL ignores the operand and changes only two flags. Select codes outside the five defined ones act as a no-op: the accumulator and flags are passed through and the write strobe stays low.

Both pins carrying data are plain combinational buses with no handshake. The surrounding pipeline registers `acc_o` when `acc_we_o` is high and registers `flags_o` in every cycle in which it issues an operation. There is no back-pressure, because the block has no storage.

Top module: `logic_alu`

## Requirements
- R1: With `op_i` = 0 (AND), `acc_o` equals `acc_i & opnd_i` and `acc_we_o` is 1.
- R2: With `op_i` = 1 (OR), `acc_o` equals `acc_i | opnd_i` and `acc_we_o` is 1.
- R3: With `op_i` = 2 (XOR), `acc_o` equals `acc_i ^ opnd_i` and `acc_we_o` is 1.
- R4: With `op_i` = 3 (TST), `acc_we_o` is 0, `acc_o` equals `acc_i`, and `flags_o` is the same as for AND with the same inputs.
- R5: With `op_i` = 4 (CPL), `acc_o` equals `~acc_i` and `acc_we_o` is 1. In `flags_o`, H (bit 4) and N (bit 1) are 1 and every other bit equals `flags_i`.
- R6: For AND, OR, XOR and TST, S (bit 7 of `flags_o`) equals bit 7 of the result, and Z (bit 6) is 1 exactly when the result is 0x00.
- R7: For AND, OR, XOR and TST, P/V (bit 2 of `flags_o`) is 1 when the result has an even number of one bits, and 0 when that number is odd.
- R8: H (bit 4) is 1 for AND and TST and 0 for OR and XOR. For all four of these operations, N (bit 1) and C (bit 0) are 0.
- R9: Bits 5 and 3 of `flags_o` always equal the same bits of `flags_i`.
- R10: Any `op_i` value from 5 to 7 gives `acc_o` = `acc_i`, `flags_o` = `flags_i` and `acc_we_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand byte (not used by CPL) |
| op_i | input | 3 | Operation select: 0 AND, 1 OR, 2 XOR, 3 TST, 4 CPL, 5-7 no-op |
| flags_i | input | 8 | Current flag byte (S7 Z6 H4 PV2 N1 C0) |
| acc_o | output | 8 | Next accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | Next flag byte |

## Verification
The bound checker evaluates the block's combinational relations whenever an input changes. It covers the write strobe for each select code, the fact that TST, CPL and the no-op codes never disturb what they must keep, and the fixed H, N and C values. It also covers the pass-through of bits 5 and 3, and the sign, zero and parity flags measured against the written result. Some things only the bench scenarios can show. These are whether the result byte itself is the right bitwise function of both operands over many operand values, and whether TST gives exactly the AND flags for the same operands. They also include whether parity is right at its extremes: 0x00, 0xFF, and single and odd bit counts.

// File: rtl/logic_alu_pkg.sv
package logic_alu_pkg;

  localparam int OP_W   = 3;
  localparam int FLAG_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_TST = 3'd3,
    OP_CPL = 3'd4
  } alu_op_e;

  // flag byte bit positions
  localparam int FB_SIGN  = 7;
  localparam int FB_ZERO  = 6;
  localparam int FB_HALF  = 4;
  localparam int FB_PAR   = 2;
  localparam int FB_SUB   = 1;
  localparam int FB_CARRY = 0;

  // bits owned by the flag generator; the rest pass through
  localparam logic [FLAG_W-1:0] OWNED_MASK =
    FLAG_W'((1 << FB_SIGN) | (1 << FB_ZERO) | (1 << FB_HALF) |
            (1 << FB_PAR)  | (1 << FB_SUB)  | (1 << FB_CARRY));

  function automatic logic is_logical(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TST);
  endfunction

endpackage

// File: rtl/logic_alu_bitop.sv
module logic_alu_bitop
  import logic_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              known_o
);

  always_comb begin
    known_o = 1'b1;
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_XOR:         res_o = a_i ^ b_i;
      OP_CPL:         res_o = ~a_i;
      default: begin
        res_o   = a_i;
        known_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/logic_alu_parity.sv
module logic_alu_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              even_o
);

  logic odd;

  always_comb begin
    odd = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      odd = odd ^ data_i[i];
    end
  end

  assign even_o = ~odd;

endmodule

// File: rtl/logic_alu_flags.sv
module logic_alu_flags
  import logic_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              even_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    flags_o = flags_i;
    if (is_logical(op_i)) begin
      flags_o[FB_SIGN]  = res_i[MSB];
      flags_o[FB_ZERO]  = (res_i == '0);
      flags_o[FB_HALF]  = (op_i == OP_AND) || (op_i == OP_TST);
      flags_o[FB_PAR]   = even_i;
      flags_o[FB_SUB]   = 1'b0;
      flags_o[FB_CARRY] = 1'b0;
    end else if (op_i == OP_CPL) begin
      flags_o[FB_HALF]  = 1'b1;
      flags_o[FB_SUB]   = 1'b1;
    end
  end

endmodule

// File: rtl/logic_alu.sv
module logic_alu
  import logic_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              acc_we_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [DATA_W-1:0] result;
  logic              op_known;
  logic              res_even;

  logic_alu_bitop #(.DATA_W(DATA_W)) u_bitop (
    .a_i     (acc_i),
    .b_i     (opnd_i),
    .op_i    (op_i),
    .res_o   (result),
    .known_o (op_known)
  );

  logic_alu_parity #(.DATA_W(DATA_W)) u_parity (
    .data_i (result),
    .even_o (res_even)
  );

  logic_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .op_i    (op_i),
    .res_i   (result),
    .even_i  (res_even),
    .flags_i (flags_i),
    .flags_o (flags_o)
  );

  // test-AND computes a result only for the flags
  assign acc_we_o = op_known && (op_i != OP_TST);
  assign acc_o    = acc_we_o ? result : acc_i;

endmodule

// File: rtl/logic_alu_chk.sv
module logic_alu_chk
  import logic_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [OP_W-1:0]   op_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              acc_we_o,
  input logic [FLAG_W-1:0] flags_o
);

  logic logical;
  assign logical = (op_i <= OP_TST);

  always_comb begin
    // R1 R2 R3 R5
    write_strobe_chk: assert (acc_we_o == (op_i <= OP_CPL && op_i != OP_TST))
      else $error("write strobe wrong for op %0d", op_i);
    // R4
    tst_keep_acc_chk: assert (op_i != OP_TST || acc_o == acc_i)
      else $error("TST changed accumulator");
    // R5
    cpl_flags_chk: assert (op_i != OP_CPL ||
                           (flags_o[FB_HALF] && flags_o[FB_SUB] &&
                            (flags_o & ~FLAG_W'((1 << FB_HALF) | (1 << FB_SUB))) ==
                            (flags_i & ~FLAG_W'((1 << FB_HALF) | (1 << FB_SUB)))))
      else $error("CPL flag rule broken");
    // R6
    sign_zero_chk: assert (!logical || op_i == OP_TST ||
                           (flags_o[FB_SIGN] == acc_o[DATA_W-1] &&
                            flags_o[FB_ZERO] == (acc_o == '0)))
      else $error("sign/zero flag disagrees with result");
    // R7
    parity_chk: assert (!logical || op_i == OP_TST ||
                        flags_o[FB_PAR] == ($countones(acc_o) % 2 == 0))
      else $error("parity flag disagrees with result");
    // R8
    fixed_flags_chk: assert (!logical ||
                             (!flags_o[FB_SUB] && !flags_o[FB_CARRY] &&
                              flags_o[FB_HALF] == (op_i == OP_AND || op_i == OP_TST)))
      else $error("fixed flag rule broken");
    // R9
    spare_bits_chk: assert ((flags_o & ~OWNED_MASK) == (flags_i & ~OWNED_MASK))
      else $error("spare flag bits changed");
    // R10
    noop_chk: assert (op_i <= OP_CPL ||
                      (!acc_we_o && acc_o == acc_i && flags_o == flags_i))
      else $error("invalid select disturbed state");
  end

endmodule

bind logic_alu logic_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .acc_i    (acc_i),
  .opnd_i   (opnd_i),
  .op_i     (op_i),
  .flags_i  (flags_i),
  .acc_o    (acc_o),
  .acc_we_o (acc_we_o),
  .flags_o  (flags_o)
);

// File: tb/logic_alu_test.sv
module logic_alu_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] acc_i, opnd_i, flags_i, acc_o, flags_o;
  logic [2:0] op_i;
  logic       acc_we_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic_alu uut (
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .op_i     (op_i),
    .flags_i  (flags_i),
    .acc_o    (acc_o),
    .acc_we_o (acc_we_o),
    .flags_o  (flags_o)
  );

  // {op, a, b, f, exp_acc, exp_we, exp_flags}
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] f;
    logic [7:0] xa;
    logic       xwe;
    logic [7:0] xf;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hF0, 8'h3C, 8'h00, 8'h30, 1'b1, 8'h14}, // R1 R7 even
    '{3'd0, 8'h0F, 8'hF0, 8'hFF, 8'h00, 1'b1, 8'h7C}, // R1 R6 zero, R9
    '{3'd1, 8'h80, 8'h01, 8'h13, 8'h81, 1'b1, 8'h84}, // R2 R6 sign, R8 clears
    '{3'd1, 8'h00, 8'h00, 8'h28, 8'h00, 1'b1, 8'h6C}, // R2 R9
    '{3'd2, 8'hFF, 8'hFE, 8'h00, 8'h01, 1'b1, 8'h00}, // R3 R7 odd
    '{3'd2, 8'hA5, 8'hA5, 8'h97, 8'h00, 1'b1, 8'h44}, // R3 R8
    '{3'd3, 8'hC1, 8'h81, 8'h00, 8'hC1, 1'b0, 8'h94}, // R4
    '{3'd3, 8'h55, 8'hAA, 8'h2B, 8'h55, 1'b0, 8'h7C}, // R4 zero
    '{3'd4, 8'h3A, 8'hFF, 8'h00, 8'hC5, 1'b1, 8'h12}, // R5
    '{3'd4, 8'h00, 8'h00, 8'hED, 8'hFF, 1'b1, 8'hFF}, // R5 keeps S Z PV C
    '{3'd5, 8'h12, 8'h34, 8'h5A, 8'h12, 1'b0, 8'h5A}, // R10
    '{3'd7, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 8'h00}, // R10
    '{3'd0, 8'hFE, 8'h7F, 8'h00, 8'h7E, 1'b1, 8'h14}, // R1 R7 six ones
    '{3'd1, 8'h07, 8'h00, 8'h00, 8'h07, 1'b1, 8'h00}  // R2 R7 three ones
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h (op=%0d a=%02h b=%02h f=%02h)",
               req, what, act, exp, op_i, acc_i, opnd_i, flags_i);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] f);
    op_i = op; acc_i = a; opnd_i = b; flags_i = f;
    #2;
  endtask

  // expectation built from the requirement text
  task automatic model(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] f,
                       output logic [7:0] xa, output logic xwe,
                       output logic [7:0] xf);
    logic [7:0] r;
    xa = a; xwe = 1'b0; xf = f;
    case (op)
      3'd0: r = a & b;
      3'd1: r = a | b;
      3'd2: r = a ^ b;
      3'd3: r = a & b;
      default: r = ~a;
    endcase
    if (op <= 3'd3) begin
      xf[7] = r[7];
      xf[6] = (r == 8'h00);
      xf[4] = (op == 3'd0 || op == 3'd3);
      xf[2] = ($countones(r) % 2 == 0);
      xf[1] = 1'b0;
      xf[0] = 1'b0;
      if (op != 3'd3) begin xa = r; xwe = 1'b1; end
    end else if (op == 3'd4) begin
      xa = r; xwe = 1'b1;
      xf[4] = 1'b1;
      xf[1] = 1'b1;
    end
  endtask

  initial begin
    op_i = 3'd5; acc_i = 8'h00; opnd_i = 8'h00; flags_i = 8'h00;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // idle state: no-op select leaves everything as given (R10)
    check("R10", "idle we", {7'd0, acc_we_o}, 8'h00);
    check("R10", "idle acc", acc_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].f);
      check("R1-table", "acc", acc_o, VECS[i].xa);
      check("R4-table", "we", {7'd0, acc_we_o}, {7'd0, VECS[i].xwe});
      check("R8-table", "flags", flags_o, VECS[i].xf);
    end

    // R4: TST flags equal AND flags for the same inputs
    for (int a = 0; a < 256; a += 7) begin
      logic [7:0] and_f;
      apply(3'd0, 8'(a), 8'(a * 3), 8'h28);
      and_f = flags_o;
      apply(3'd3, 8'(a), 8'(a * 3), 8'h28);
      check("R4", "tst vs and flags", flags_o, and_f);
      check("R4", "tst acc kept", acc_o, 8'(a));
    end

    // sweep of every select against the requirement model (R1 R2 R3 R5 R6 R7 R9 R10)
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] b, f, xa, xf;
          logic xwe;
          b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'(a * 13 + 1);
          f = (k[0]) ? 8'hFF : 8'(a ^ 8'h28);
          model(3'(op), 8'(a), b, f, xa, xwe, xf);
          apply(3'(op), 8'(a), b, f);
          check("R1R2R3R5R10", "sweep acc", acc_o, xa);
          check("R10", "sweep we", {7'd0, acc_we_o}, {7'd0, xwe});
          check("R6R7R9", "sweep flags", flags_o, xf);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule